// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a 16-bit offset into a 20-bit physical address by adding it to a 16-bit segment base. The base is shifted left by four bits before the add, so each segment starts on a 16-byte boundary and reaches at most 64 KB. The physical space is 1 MB. The unit holds four segment registers: code, data, stack and extra.

Each request carries an access class and an optional override. The class names the default segment. The override can replace that segment, but only for data and extra-data requests. Instruction fetches always use the code segment. Stack requests always use the stack segment.

Software or a sequencer loads the segment registers through a synchronous write port. The address and its valid flag come out of a register one cycle after the request. Segments may overlap, and the unit makes no check for two segment/offset pairs that reach the same address.

Top module: `seg_agu`

## Requirements
- R1: After reset, `pa_valid` is 0 and `pa_addr` is 0. The code segment resets to 0xFFFF and the other three segments reset to 0. A fetch at offset 0 therefore gives 0xFFFF0, and a data access at offset 0x10 gives 0x00010.
- R2: The physical address is segment × 16 + offset. For example, segment 0x135F with offset 0x0102 gives 0x136F2. Two different pairs that reach the same location, such as 0x1000:0x0020 and 0x1001:0x0010, both give 0x10020 without complaint.
- R3: Any carry out of bit 19 is dropped, so the address wraps modulo 2^20. For example, 0xFFFF:0x0010 gives 0x00000, and 0xFFFF:0xFFFF gives 0x0FFEF.
- R4: Class 0 (instruction fetch) always uses the code segment (index 0), even when the override is enabled.
- R5: Class 2 (stack) always uses the stack segment (index 2), even when the override is enabled.
- R6: Without an override, class 1 (data) uses the data segment (index 1), and class 3 (extra data) uses the extra segment (index 3).
- R7: For class 1 or class 3 with `req_ovr_en`=1, the unit uses the segment named by `req_ovr_sel`. The indices are 0 code, 1 data, 2 stack and 3 extra.
- R8: When `seg_we` is high at a clock edge, segment `seg_wsel` takes the value `seg_wdata`. A request accepted at that same edge still uses the old value. Requests from the next edge onward use the new value.
- R9: `pa_valid` equals `req_valid` delayed by one clock. `pa_addr` carries the address of the request accepted at the previous edge.
- R10: `pa_addr` keeps its previous value in every cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_class | input | 2 | Access class: 0 fetch, 1 data, 2 stack, 3 extra |
| req_ovr_en | input | 1 | Segment override enable |
| req_ovr_sel | input | 2 | Override segment index |
| req_offset | input | 16 | Offset within the segment |
| seg_we | input | 1 | Segment register write strobe |
| seg_wsel | input | 2 | Index of the segment register to write |
| seg_wdata | input | 16 | Segment write value |
| pa_valid | output | 1 | Registered address valid |
| pa_addr | output | 20 | Registered physical address |

## Verification
The arithmetic is driven with a worked example, with two aliasing pairs, and with bases and offsets near the top of the range. The aliasing pairs show that the shift happens before the add. The top-of-range cases show whether carries are dropped above bit 19.

Segment selection is tried for every class, with the override both off and on. Each register holds a distinct base, so any wrong pick shows up as a wrong address.

A write paired with a same-cycle request, followed by a second request, shows whether the old or the new base is used. Idle cycles between requests show the valid timing and whether the address is held.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

   typedef enum logic [1:0] {
      CLS_FETCH = 2'd0,
      CLS_DATA  = 2'd1,
      CLS_STACK = 2'd2,
      CLS_EXTRA = 2'd3
   } acc_class_e;

   localparam int unsigned SEG_IDX_CODE  = 0;
   localparam int unsigned SEG_IDX_DATA  = 1;
   localparam int unsigned SEG_IDX_STACK = 2;
   localparam int unsigned SEG_IDX_EXTRA = 3;
   localparam int unsigned SEG_COUNT     = 4;

endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
   parameter int unsigned SEG_W    = 16,
   parameter int unsigned NUM_SEG  = 4,
   parameter int unsigned CODE_IDX = 0,
   parameter logic [SEG_W-1:0] CODE_RST  = '1,
   parameter logic [SEG_W-1:0] OTHER_RST = '0,
   localparam int unsigned SEL_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [SEL_W-1:0]                wsel,
   input  logic [SEG_W-1:0]                wdata,
   output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_q
);

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_reg
      localparam logic [SEG_W-1:0] RST_V = (i == CODE_IDX) ? CODE_RST : OTHER_RST;
      always_ff @(posedge clk) begin
         if (!rst_n)
            seg_q[i] <= RST_V;
         else if (we && (wsel == SEL_W'(i)))
            seg_q[i] <= wdata;
      end
   end

   assert_load_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (seg_q[$past(wsel)] == $past(wdata)));

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_agu_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [1:0]                        cls,
   input  logic                              ovr_en,
   input  logic [1:0]                        ovr_sel,
   input  logic [SEG_COUNT-1:0][SEG_W-1:0]   seg_q,
   output logic [1:0]                        sel_idx,
   output logic [SEG_W-1:0]                  seg_val
);

   acc_class_e cls_e;

   always_comb begin
      cls_e = acc_class_e'(cls);
      unique case (cls_e)
         CLS_FETCH: sel_idx = 2'(SEG_IDX_CODE);
         CLS_STACK: sel_idx = 2'(SEG_IDX_STACK);
         CLS_DATA:  sel_idx = ovr_en ? ovr_sel : 2'(SEG_IDX_DATA);
         CLS_EXTRA: sel_idx = ovr_en ? ovr_sel : 2'(SEG_IDX_EXTRA);
         default:   sel_idx = 2'(SEG_IDX_DATA);
      endcase
      seg_val = seg_q[sel_idx];
   end

   assert_fetch_code_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (cls == 2'd0) |-> (seg_val == seg_q[SEG_IDX_CODE]));

   assert_stack_seg_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cls == 2'd2) |-> (seg_val == seg_q[SEG_IDX_STACK]));

endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
   parameter int unsigned SEG_W  = 16,
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned SHIFT  = 4,
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned SPLIT  = 1
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned HI_W = ADDR_W - SHIFT;

   if (SPLIT != 0) begin : g_split
      logic [HI_W-1:0] hi_sum;
      always_comb begin
         hi_sum = HI_W'(seg) + HI_W'(off >> SHIFT);
         addr   = {hi_sum, off[SHIFT-1:0]};
      end
   end else begin : g_full
      always_comb begin
         addr = (ADDR_W'(seg) << SHIFT) + ADDR_W'(off);
      end
   end

endmodule

// File: rtl/seg_agu.sv
module seg_agu
   import seg_agu_pkg::*;
#(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SHIFT     = 4,
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned SPLIT_ADD = 1,
   parameter logic [SEG_W-1:0] CODE_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_class,
   input  logic              req_ovr_en,
   input  logic [1:0]        req_ovr_sel,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic              seg_we,
   input  logic [1:0]        seg_wsel,
   input  logic [SEG_W-1:0]  seg_wdata,
   output logic              pa_valid,
   output logic [ADDR_W-1:0] pa_addr
);

   if (ADDR_W != SEG_W + SHIFT) begin : g_bad_width
      $error("seg_agu: ADDR_W must equal SEG_W + SHIFT");
   end
   if (OFF_W > ADDR_W || OFF_W <= SHIFT) begin : g_bad_off
      $error("seg_agu: OFF_W out of range");
   end

   logic [SEG_COUNT-1:0][SEG_W-1:0] seg_q;
   logic [1:0]                      sel_idx;
   logic [SEG_W-1:0]                seg_val;
   logic [ADDR_W-1:0]               sum;

   seg_bank #(
      .SEG_W     (SEG_W),
      .NUM_SEG   (SEG_COUNT),
      .CODE_IDX  (SEG_IDX_CODE),
      .CODE_RST  (CODE_RST),
      .OTHER_RST ('0)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (seg_we),
      .wsel  (seg_wsel),
      .wdata (seg_wdata),
      .seg_q (seg_q)
   );

   seg_select #(
      .SEG_W (SEG_W)
   ) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .cls     (req_class),
      .ovr_en  (req_ovr_en),
      .ovr_sel (req_ovr_sel),
      .seg_q   (seg_q),
      .sel_idx (sel_idx),
      .seg_val (seg_val)
   );

   addr_adder #(
      .SEG_W  (SEG_W),
      .OFF_W  (OFF_W),
      .SHIFT  (SHIFT),
      .ADDR_W (ADDR_W),
      .SPLIT  (SPLIT_ADD)
   ) u_add (
      .seg  (seg_val),
      .off  (req_offset),
      .addr (sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa_valid <= 1'b0;
         pa_addr  <= '0;
      end else begin
         pa_valid <= req_valid;
         if (req_valid)
            pa_addr <= sum;
      end
   end

   assert_valid_follows_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> pa_valid);

   assert_idle_no_valid_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !pa_valid);

   assert_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(pa_addr));

   assert_low_nibble_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (pa_addr[SHIFT-1:0] == $past(req_offset[SHIFT-1:0])));

endmodule

// File: tb/seg_agu_test.sv
module seg_agu_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_class = 2'd0;
   logic        req_ovr_en = 1'b0;
   logic [1:0]  req_ovr_sel = 2'd0;
   logic [15:0] req_offset = 16'd0;
   logic        seg_we = 1'b0;
   logic [1:0]  seg_wsel = 2'd0;
   logic [15:0] seg_wdata = 16'd0;
   logic        pa_valid;
   logic [19:0] pa_addr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] model_seg [4];
   logic [19:0] last_addr = 20'd0;
   logic [20:0] q_exp [$];
   string       q_tag [$];

   seg_agu uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
      .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel), .req_offset(req_offset),
      .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
      .pa_valid(pa_valid), .pa_addr(pa_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
      return ({4'b0, s} << 4) + {4'b0, o};
   endfunction

   function automatic int pick(input logic [1:0] c, input logic oe, input logic [1:0] os);
      if (c == 2'd0) return 0;
      if (c == 2'd2) return 2;
      if (oe) return int'(os);
      return (c == 2'd1) ? 1 : 3;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic v, input logic [1:0] c, input logic oe, input logic [1:0] os,
                      input logic [15:0] off, input logic we, input logic [1:0] ws,
                      input logic [15:0] wd, input string tag);
      logic [19:0] ea;
      req_valid = v; req_class = c; req_ovr_en = oe; req_ovr_sel = os; req_offset = off;
      seg_we = we; seg_wsel = ws; seg_wdata = wd;
      ea = v ? phys(model_seg[pick(c, oe, os)], off) : last_addr;
      last_addr = ea;
      q_exp.push_back({v, ea});
      q_tag.push_back(tag);
      if (we) model_seg[ws] = wd;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] ws, input logic [15:0] wd, input string tag);
      cyc(1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, ws, wd, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // monitor: compare each result with the next scoreboard entry
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_exp.size() > 0) begin
            logic [20:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check({t, " valid"}, {31'd0, pa_valid}, {31'd0, e[20]});
            check({t, " addr"}, {12'd0, pa_addr}, {12'd0, e[19:0]});
         end
      end
   end

   initial begin
      model_seg[0] = 16'hFFFF;
      model_seg[1] = 16'h0000;
      model_seg[2] = 16'h0000;
      model_seg[3] = 16'h0000;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset valid", {31'd0, pa_valid}, 32'd0);
      check("R1 reset addr", {12'd0, pa_addr}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1, 2'd0, 0, 2'd0, 16'h0000, 0, 2'd0, 16'h0, "R1 code reset");
      cyc(1, 2'd1, 0, 2'd0, 16'h0010, 0, 2'd0, 16'h0, "R1 data reset");
      wr(2'd0, 16'h135F, "R8 write code");
      cyc(1, 2'd0, 0, 2'd0, 16'h0102, 0, 2'd0, 16'h0, "R2 example");
      wr(2'd1, 16'hFFFF, "R8 write data");
      cyc(1, 2'd1, 0, 2'd0, 16'h0010, 0, 2'd0, 16'h0, "R3 wrap zero");
      cyc(1, 2'd1, 0, 2'd0, 16'hFFFF, 0, 2'd0, 16'h0, "R3 wrap max");
      wr(2'd2, 16'h2000, "R8 write stack");
      wr(2'd3, 16'h3000, "R8 write extra");
      cyc(1, 2'd0, 1, 2'd1, 16'h0005, 0, 2'd0, 16'h0, "R4 fetch ignores override");
      cyc(1, 2'd2, 1, 2'd3, 16'h0004, 0, 2'd0, 16'h0, "R5 stack ignores override");
      cyc(1, 2'd1, 0, 2'd0, 16'h0001, 0, 2'd0, 16'h0, "R6 data default");
      cyc(1, 2'd3, 0, 2'd0, 16'h0001, 0, 2'd0, 16'h0, "R6 extra default");
      cyc(1, 2'd1, 1, 2'd2, 16'h0008, 0, 2'd0, 16'h0, "R7 data override stack");
      cyc(1, 2'd3, 1, 2'd0, 16'h0003, 0, 2'd0, 16'h0, "R7 extra override code");
      cyc(1, 2'd1, 0, 2'd0, 16'h0000, 1, 2'd1, 16'h1234, "R8 same-cycle old value");
      cyc(1, 2'd1, 0, 2'd0, 16'h0000, 0, 2'd0, 16'h0, "R8 new value");
      cyc(0, 2'd1, 0, 2'd0, 16'h7777, 0, 2'd0, 16'h0, "R9 R10 idle hold");
      cyc(0, 2'd2, 0, 2'd0, 16'h1111, 0, 2'd0, 16'h0, "R10 idle hold 2");
      wr(2'd2, 16'h1000, "R8 alias setup a");
      wr(2'd3, 16'h1001, "R8 alias setup b");
      cyc(1, 2'd2, 0, 2'd0, 16'h0020, 0, 2'd0, 16'h0, "R2 alias a");
      cyc(1, 2'd3, 0, 2'd0, 16'h0010, 0, 2'd0, 16'h0, "R2 alias b");
      cyc(0, 2'd0, 0, 2'd0, 16'h0000, 0, 2'd0, 16'h0, "R9 final idle");
      repeat (3) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

endmodule